// File: doc/BRIEF.md
# Vectored Interrupt Sequencer with Return-Address Stack

This block controls interrupt entry for a single-cycle Harvard processor core and owns the core's hardware return-address stack. Three active-low request lines are qualified against the falling clock edge. Each line is masked by its own enable bit and also by a global enable. When a request is accepted, one sequential fetch slot is replaced by a fetch from that line's vector address. The slot after it acts as an injected call that saves the interrupted return address.

The same stack, six entries deep, serves the decoder's ordinary call and return strobes. A push onto a full stack drops the oldest address and sets a sticky overflow flag. A pop from an empty stack yields address zero and sets a sticky underflow flag. In the target core, line 1 is wired to the serial codec unit and line 2 to the 13-bit timer. Line 0 is general purpose.

Top module: `irq_vec_seq`

## Requirements
- R1: A request is taken into account only if its `irq_ni` bit is seen low at two consecutive falling clock edges. It then becomes pending at the next rising edge. A low level that spans only one falling edge has no effect.
- R2: When several enabled requests are pending, the one with the lowest index is taken. The vector of line i is `VEC_BASE + i*VEC_STEP`, which is 0x0010, 0x0018 and 0x0020 by default.
- R3: In the cycle a request is accepted, `fetch_addr_o` shows that line's vector in place of `pc_next_i`, and `vec_fetch_o` is high for that one cycle only.
- R4: The cycle after acceptance is a call slot. It pushes the `pc_next_i` value of the acceptance cycle and passes `pc_next_i` through to `fetch_addr_o`. `call_i`, `ret_i` and `reti_i` are ignored in this slot.
- R5: A line whose `irq_en_i` bit is 0 is never accepted, and it does not stop other enabled lines from being accepted.
- R6: Acceptance clears the global enable. No further request is accepted until a cycle with `reti_i` has passed, and a pending request may then be accepted in the very next cycle.
- R7: In a cycle where `call_i`, `ret_i` or `reti_i` is high, no request is accepted. A pending request waits for the next free cycle.
- R8: `call_i` pushes `pc_next_i` and drives `fetch_addr_o` to `call_tgt_i`. `ret_i` or `reti_i` pops the stack and drives the popped address onto `fetch_addr_o`, in last-in first-out order.
- R9: The stack holds 6 addresses. A push onto a full stack discards the oldest entry and sets `ovf_o`, which stays high until reset.
- R10: A pop from an empty stack drives `fetch_addr_o` to 0 and sets `unf_o`, which stays high until reset.
- R11: Reset empties the stack, clears pending requests and both flags, and sets the global enable. After reset, `fetch_addr_o` follows `pc_next_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 3 | Interrupt requests, active low |
| irq_en_i | input | 3 | Per-line enable mask |
| pc_next_i | input | 16 | Sequential next fetch address from the core |
| call_i | input | 1 | Decoder call strobe |
| call_tgt_i | input | 16 | Call target address |
| ret_i | input | 1 | Decoder return strobe |
| reti_i | input | 1 | Decoder return-from-interrupt strobe |
| fetch_addr_o | output | 16 | Program fetch address for this cycle |
| vec_fetch_o | output | 1 | This cycle's fetch is an interrupt vector |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
A wrong stack pointer or a corrupted entry shows at the next return strobe as a wrong `fetch_addr_o`. A lost or extra push shows as a premature zero address on a pop from an empty stack, or as `unf_o` rising, on the return that crosses the error. A stuck pending bit or global enable shows as a vector fetch that appears or fails to appear within two cycles of the qualifying falling edges or of the `reti_i` cycle. A broken call slot shows one cycle after `vec_fetch_o`, either as a fetch address other than `pc_next_i` or as a wrong return address later on.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned IRQ_LINES = 3;
  localparam int unsigned PC_AW     = 16;
  localparam int unsigned STK_DEPTH = 6;

  typedef enum logic {
    SEQ_RUN,
    SEQ_CALL
  } seq_st_e;
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int unsigned N  = 3,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_ni,
  input  logic [N-1:0]  en_i,
  input  logic          clr_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] lo1_q, lo2_q, pend_q, elig;

  // qualify on falling edges: low at two consecutive ones
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo1_q <= '0;
      lo2_q <= '0;
    end else begin
      lo1_q <= ~irq_ni;
      lo2_q <= lo1_q;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else pend_q[g] <= (pend_q[g] | (lo1_q[g] & lo2_q[g]))
                        & ~(clr_i && (idx_o == IW'(g)));
    end
  end

  assign elig  = pend_q & en_i;
  assign any_o = |elig;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pc_stack.sv
module pc_stack #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DEPTH = 6,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] din_i,
  output logic [AW-1:0] top_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [AW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full, empty;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else if (push_i) begin
      if (full) begin
        // drop oldest: shift down, new entry on top
        for (int i = 0; i < DEPTH - 1; i++) mem_q[i] <= mem_q[i+1];
        mem_q[DEPTH-1] <= din_i;
        ovf_o <= 1'b1;
      end else begin
        mem_q[cnt_q] <= din_i;
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (pop_i) begin
      if (empty) unf_o <= 1'b1;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_o = empty ? '0 : mem_q[cnt_q - 1'b1];
  assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
  import irq_vec_pkg::*;
#(
  parameter int unsigned AW       = PC_AW,
  parameter int unsigned N_IRQ    = IRQ_LINES,
  parameter int unsigned DEPTH    = STK_DEPTH,
  parameter int unsigned VEC_BASE = 16'h0010,
  parameter int unsigned VEC_STEP = 16'h0008,
  localparam int unsigned IW      = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_ni,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [AW-1:0]    pc_next_i,
  input  logic             call_i,
  input  logic [AW-1:0]    call_tgt_i,
  input  logic             ret_i,
  input  logic             reti_i,
  output logic [AW-1:0]    fetch_addr_o,
  output logic             vec_fetch_o,
  output logic             ovf_o,
  output logic             unf_o
);
  seq_st_e       st_q;
  logic          gie_q;
  logic [AW-1:0] ret_q;
  logic          any_req, take, strobe;
  logic [IW-1:0] pick_idx;
  logic          push, pop;
  logic [AW-1:0] push_data, stk_top;
  logic [CW-1:0] stk_cnt;
  logic [AW-1:0] vec_tbl [N_IRQ];

  for (genvar g = 0; g < N_IRQ; g++) begin : g_vec
    assign vec_tbl[g] = AW'(VEC_BASE + g * VEC_STEP);
  end

  irq_sampler #(.N(N_IRQ)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_ni (irq_ni),
    .en_i   (irq_en_i),
    .clr_i  (take),
    .any_o  (any_req),
    .idx_o  (pick_idx)
  );

  pc_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .din_i  (push_data),
    .top_o  (stk_top),
    .cnt_o  (stk_cnt),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o)
  );

  assign strobe = call_i | ret_i | reti_i;
  assign take   = (st_q == SEQ_RUN) && gie_q && any_req && !strobe;

  always_comb begin
    push         = 1'b0;
    pop          = 1'b0;
    push_data    = pc_next_i;
    fetch_addr_o = pc_next_i;
    vec_fetch_o  = 1'b0;
    if (st_q == SEQ_CALL) begin
      // injected call: save interrupted address, decoder strobes dropped
      push      = 1'b1;
      push_data = ret_q;
    end else if (take) begin
      fetch_addr_o = vec_tbl[pick_idx];
      vec_fetch_o  = 1'b1;
    end else if (call_i) begin
      push         = 1'b1;
      fetch_addr_o = call_tgt_i;
    end else if (ret_i || reti_i) begin
      pop          = 1'b1;
      fetch_addr_o = stk_top;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_RUN;
      gie_q <= 1'b1;
      ret_q <= '0;
    end else begin
      st_q <= take ? SEQ_CALL : SEQ_RUN;
      if (take) begin
        ret_q <= pc_next_i;
        gie_q <= 1'b0;
      end else if ((st_q == SEQ_RUN) && reti_i) begin
        gie_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vec_seq_chk.sv
module irq_vec_seq_chk #(
  parameter int unsigned AW       = 16,
  parameter int unsigned N_IRQ    = 3,
  parameter int unsigned DEPTH    = 6,
  parameter int unsigned VEC_BASE = 16'h0010,
  parameter int unsigned VEC_STEP = 16'h0008,
  localparam int unsigned IW      = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_IRQ-1:0] irq_en_i,
  input logic [AW-1:0]    pc_next_i,
  input logic             call_i,
  input logic             ret_i,
  input logic             reti_i,
  input logic [AW-1:0]    fetch_addr_o,
  input logic             vec_fetch_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic             gie_q,
  input logic [IW-1:0]    pick_idx,
  input logic [CW-1:0]    stk_cnt
);
  logic vec_hit;
  always_comb begin
    vec_hit = 1'b0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (fetch_addr_o == AW'(VEC_BASE + i * VEC_STEP)) vec_hit = 1'b1;
    end
  end

  // R2
  vec_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fetch_o |-> vec_hit);

  // R3
  vec_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fetch_o |=> !vec_fetch_o);

  // R4
  call_slot_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fetch_o |=> (fetch_addr_o == pc_next_i));

  // R4
  call_slot_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_fetch_o && (stk_cnt < CW'(DEPTH))) |=> ##1 (stk_cnt == $past(stk_cnt, 2) + 1'b1));

  // R5
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fetch_o |-> irq_en_i[pick_idx]);

  // R6
  gie_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fetch_o |=> !gie_q);

  // R7
  strobe_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i || ret_i || reti_i) |-> !vec_fetch_o);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R9
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_cnt <= CW'(DEPTH));

  // R10
  unf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
endmodule

bind irq_vec_seq irq_vec_seq_chk #(
  .AW(AW), .N_IRQ(N_IRQ), .DEPTH(DEPTH), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_en_i     (irq_en_i),
  .pc_next_i    (pc_next_i),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .reti_i       (reti_i),
  .fetch_addr_o (fetch_addr_o),
  .vec_fetch_o  (vec_fetch_o),
  .ovf_o        (ovf_o),
  .unf_o        (unf_o),
  .gie_q        (gie_q),
  .pick_idx     (pick_idx),
  .stk_cnt      (stk_cnt)
);

// File: tb/tb_irq_vec_seq.sv
module tb_irq_vec_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] V0 = 16'h0010, V1 = 16'h0018, V2 = 16'h0020;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  irq_ni = 3'b111;
  logic [2:0]  irq_en_i = 3'b111;
  logic [15:0] pc_next_i = 16'h0100;
  logic        call_i = 1'b0;
  logic [15:0] call_tgt_i = '0;
  logic        ret_i = 1'b0;
  logic        reti_i = 1'b0;
  logic [15:0] fetch_addr_o;
  logic        vec_fetch_o, ovf_o, unf_o;

  int total = 0;
  int bad = 0;

  irq_vec_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_ni(irq_ni), .irq_en_i(irq_en_i),
    .pc_next_i(pc_next_i), .call_i(call_i), .call_tgt_i(call_tgt_i),
    .ret_i(ret_i), .reti_i(reti_i), .fetch_addr_o(fetch_addr_o),
    .vec_fetch_o(vec_fetch_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive just after a rising edge; checks follow after settle
  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic settle();
    #3;
  endtask

  task automatic idle_strobes();
    call_i = 1'b0; ret_i = 1'b0; reti_i = 1'b0;
  endtask

  task automatic do_reset();
    idle_strobes();
    irq_ni = 3'b111; irq_en_i = 3'b111; pc_next_i = 16'h0100;
    rst_ni = 1'b0;
    repeat (2) step();
    rst_ni = 1'b1;
  endtask

  // wait for a vector fetch, return cycles waited (99 if none)
  task automatic wait_vec(input int lim, output int n);
    n = 99;
    for (int c = 1; c <= lim; c++) begin
      step(); settle();
      if (vec_fetch_o) begin n = c; break; end
    end
  endtask

  task automatic t_reset();
    do_reset();
    pc_next_i = 16'h0123;
    settle();
    chk("R11 fetch follows pc", fetch_addr_o, 16'h0123);
    chk("R11 ovf clear", {15'b0, ovf_o}, 16'h0);
    chk("R11 unf clear", {15'b0, unf_o}, 16'h0);
    chk("R11 no vec", {15'b0, vec_fetch_o}, 16'h0);
  endtask

  task automatic t_stack();
    do_reset();
    for (int k = 1; k <= 7; k++) begin
      step();
      call_i = 1'b1; pc_next_i = 16'h0200 + 16'(k); call_tgt_i = 16'h0300 + 16'(k);
      settle();
      chk("R8 call target", fetch_addr_o, 16'h0300 + 16'(k));
      if (k == 7) chk("R9 ovf before 7th push", {15'b0, ovf_o}, 16'h0);
    end
    step(); idle_strobes(); settle();
    chk("R9 ovf after full push", {15'b0, ovf_o}, 16'h1);
    for (int j = 1; j <= 6; j++) begin
      step(); ret_i = 1'b1; settle();
      chk("R8 R9 pop order", fetch_addr_o, 16'h0208 - 16'(j));
    end
    step(); ret_i = 1'b1; settle();
    chk("R10 empty pop addr", fetch_addr_o, 16'h0000);
    chk("R10 unf before edge", {15'b0, unf_o}, 16'h0);
    step(); idle_strobes(); settle();
    chk("R10 unf sticky", {15'b0, unf_o}, 16'h1);
    step(); settle();
    chk("R9 ovf sticky", {15'b0, ovf_o}, 16'h1);
    chk("R10 unf still", {15'b0, unf_o}, 16'h1);
  endtask

  task automatic t_basic();
    int n;
    do_reset();
    step();
    irq_ni = 3'b101; pc_next_i = 16'h0400;
    wait_vec(5, n);
    chk("R1 R3 latency", 16'(n), 16'd2);
    chk("R3 vector line1", fetch_addr_o, V1);
    irq_ni = 3'b111;
    step();
    pc_next_i = 16'h0019; call_i = 1'b1; call_tgt_i = 16'h0777;
    settle();
    chk("R4 call slot addr", fetch_addr_o, 16'h0019);
    chk("R3 vec one cycle", {15'b0, vec_fetch_o}, 16'h0);
    step(); idle_strobes(); pc_next_i = 16'h001A;
    step(); reti_i = 1'b1; settle();
    chk("R4 return addr", fetch_addr_o, 16'h0400);
    step(); idle_strobes(); ret_i = 1'b1; settle();
    chk("R4 call strobe ignored", fetch_addr_o, 16'h0000);
    step(); idle_strobes();
  endtask

  task automatic t_short();
    int n;
    do_reset();
    step();
    irq_ni = 3'b110;
    #6;
    irq_ni = 3'b111;
    wait_vec(5, n);
    chk("R1 short pulse ignored", 16'(n), 16'd99);
  endtask

  task automatic t_priority();
    int n;
    do_reset();
    step();
    irq_ni = 3'b010; pc_next_i = 16'h0500;
    wait_vec(5, n);
    chk("R2 lowest wins", fetch_addr_o, V0);
    irq_ni = 3'b011;
    step(); pc_next_i = 16'h0011;
    wait_vec(3, n);
    chk("R6 no reentry", 16'(n), 16'd99);
    step(); reti_i = 1'b1; settle();
    chk("R6 reti returns", fetch_addr_o, 16'h0500);
    chk("R7 no take on reti", {15'b0, vec_fetch_o}, 16'h0);
    step(); idle_strobes(); settle();
    chk("R6 R2 next line taken", fetch_addr_o, V2);
    chk("R6 vec after reti", {15'b0, vec_fetch_o}, 16'h1);
    irq_ni = 3'b111;
    step();
  endtask

  task automatic t_mask();
    int n;
    do_reset();
    irq_en_i = 3'b110;
    step();
    irq_ni = 3'b110;
    wait_vec(5, n);
    chk("R5 masked not taken", 16'(n), 16'd99);
    irq_ni = 3'b100;
    wait_vec(5, n);
    chk("R5 other line taken", fetch_addr_o, V1);
    irq_ni = 3'b111;
    step();
  endtask

  task automatic t_defer();
    do_reset();
    step();
    irq_ni = 3'b011; pc_next_i = 16'h0600;
    step();
    step();
    call_i = 1'b1; call_tgt_i = 16'h0900; pc_next_i = 16'h0601;
    settle();
    chk("R7 call wins slot", fetch_addr_o, 16'h0900);
    chk("R7 no vec with call", {15'b0, vec_fetch_o}, 16'h0);
    step(); idle_strobes(); pc_next_i = 16'h0901; settle();
    chk("R7 deferred vector", fetch_addr_o, V2);
    irq_ni = 3'b111;
    step(); pc_next_i = 16'h0021;
    step(); reti_i = 1'b1; settle();
    chk("R8 reti pops irq return", fetch_addr_o, 16'h0901);
    step(); idle_strobes(); ret_i = 1'b1; settle();
    chk("R8 ret pops call return", fetch_addr_o, 16'h0601);
    step(); idle_strobes();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_stack();
    t_basic();
    t_short();
    t_priority();
    t_mask();
    t_defer();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule